// File: doc/BRIEF.md
# I2C SCL High/Low Period Generator

This block produces the SCL clock of an I2C controller that drives the bus. It drives SCL open-drain: its only output is an enable that pulls the line low. The block keeps four programmable period counts: a high count and a low count for standard speed, and a high count and a low count for fast speed. A two-bit speed field picks which pair drives the waveform. The low phase is timed from the cycle in which the block pulls SCL low. The high phase is timed only after the sampled SCL line is seen high, so a target that holds SCL low stretches the clock by exactly the time it holds it.

The block serves a byte/bit sequencer that sits outside it. That sequencer raises `ctl_run` to request clock periods and drops it to stop. When it stops, the generator completes the phase that is in progress and leaves SCL released. The period counts can be rewritten only while `ctl_en` is low. Dropping `ctl_en` releases SCL at once.

Top module: `scl_gen`

## Requirements
- R1: After reset `scl_oe` is 0, and the counts take their parameter defaults: standard high 20, standard low 30, fast high 4, fast low 9.
- R2: `ctl_speed` equal to 2'b10 selects the fast pair. Any other value, including 2'b01, selects the standard pair.
- R3: When the block is enabled, idle and `ctl_run` is seen high at a clock edge, `scl_oe` rises at that edge. It then stays 1 for exactly low count + 1 cycles.
- R4: On an edge where `cnt_we` is 1 and `ctl_en` is 0, `cnt_wdata` is written to the count chosen by `cnt_sel`: 0 standard high, 1 standard low, 2 fast high, 3 fast low. A write while `ctl_en` is 1 is ignored.
- R5: When SCL follows the output without delay, `scl_oe` stays 0 for exactly high count + 8 cycles between two low phases.
- R6: The high count starts only when the sampled SCL input reads high. A line held low after release lengthens the released time cycle for cycle.
- R7: `ctl_en` low at a clock edge forces `scl_oe` to 0 at that edge, and the block stays idle.
- R8: With `ctl_run` low, a low phase in progress completes its full length, and a high phase in progress also completes. After that, `scl_oe` stays 0 until `ctl_run` is high again.
- R9: The count and speed selection are captured at the start of each phase. A speed change during a low phase affects only the phases that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable; counts writable only while 0 |
| ctl_run | input | 1 | Request for SCL periods from the sequencer |
| ctl_speed | input | 2 | 2'b10 fast pair, otherwise standard pair |
| cnt_we | input | 1 | Count write strobe |
| cnt_sel | input | 2 | Count index for a write |
| cnt_wdata | input | CNT_W | Count write value |
| scl_in | input | 1 | SCL line level as seen on the pad |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |

## Verification
Two events can land in the same cycle: the final cycle of a low phase and a drop of `ctl_run`. The bench lowers `ctl_run` exactly in the last low cycle, and separately in the first low cycle. In both cases it checks that the low phase keeps its full length and that SCL then stays released with no further low phase. A second coincidence is a count write in a cycle where the block is enabled. The bench judges that case by measuring the next low period, which must still use the old count.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  localparam logic [1:0] SPEED_FAST = 2'b10;
  localparam int HIGH_OVERHEAD = 8;
  // cycles spent in PH_WAIT before PH_HIGH when the line rises at once
  localparam int SAMPLE_LAT = 2;
  localparam int HIGH_LOAD_ADD = HIGH_OVERHEAD - SAMPLE_LAT - 1;

  localparam int IDX_STD_HI  = 0;
  localparam int IDX_STD_LO  = 1;
  localparam int IDX_FAST_HI = 2;
  localparam int IDX_FAST_LO = 3;
endpackage

// File: rtl/scl_count_bank.sv
module scl_count_bank #(
  parameter int CNT_W = 16,
  parameter int RST_STD_HI = 20,
  parameter int RST_STD_LO = 30,
  parameter int RST_FAST_HI = 4,
  parameter int RST_FAST_LO = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       speed,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] lo_cnt
);
  import scl_gen_pkg::*;

  localparam int NREG = 4;

  function automatic logic [CNT_W-1:0] rst_val(input int idx);
    case (idx)
      IDX_STD_HI:  return CNT_W'(RST_STD_HI);
      IDX_STD_LO:  return CNT_W'(RST_STD_LO);
      IDX_FAST_HI: return CNT_W'(RST_FAST_HI);
      default:     return CNT_W'(RST_FAST_LO);
    endcase
  endfunction

  logic [NREG-1:0][CNT_W-1:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= rst_val(i);
      else if (we && !en && (sel == 2'(i)))
        regs[i] <= wdata;
    end
  end

  logic fast;
  assign fast   = (speed == SPEED_FAST);
  assign hi_cnt = fast ? regs[IDX_FAST_HI] : regs[IDX_STD_HI];
  assign lo_cnt = fast ? regs[IDX_FAST_LO] : regs[IDX_STD_LO];

  // R4: counts hold while the controller was enabled at the last edge
  a_r4_locked_when_enabled: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> $stable(regs));
endmodule

// File: rtl/scl_sampler.sv
module scl_sampler (
  input  logic clk,
  input  logic rst,
  input  logic pad_in,
  output logic level_q
);
  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= pad_in;
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             scl_q,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic             oe
);
  import scl_gen_pkg::*;

  localparam int CW = CNT_W + 1;

  phase_e        state, state_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    if (!en) begin
      state_n = PH_IDLE;
      cnt_n   = '0;
    end else begin
      case (state)
        PH_IDLE: if (run) begin
          state_n = PH_LOW;
          cnt_n   = CW'(lo_cnt);
        end
        PH_LOW: begin
          if (cnt == '0) state_n = run ? PH_WAIT : PH_IDLE;
          else           cnt_n   = cnt - 1'b1;
        end
        PH_WAIT: if (scl_q) begin
          state_n = PH_HIGH;
          cnt_n   = CW'(hi_cnt) + CW'(HIGH_LOAD_ADD);
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            if (run) begin
              state_n = PH_LOW;
              cnt_n   = CW'(lo_cnt);
            end else begin
              state_n = PH_IDLE;
            end
          end else begin
            cnt_n = cnt - 1'b1;
          end
        end
        default: state_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE;
      cnt   <= '0;
      oe    <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      oe    <= (state_n == PH_LOW);
    end
  end

  // checker-side counter of cycles spent in the current low phase
  logic [CW-1:0] lo_seen;
  logic [CW-1:0] lo_used;
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_seen <= '0;
      lo_used <= '0;
    end else if (state_n == PH_LOW && state != PH_LOW) begin
      lo_seen <= '0;
      lo_used <= cnt_n;
    end else if (state == PH_LOW) begin
      lo_seen <= lo_seen + 1'b1;
    end
  end

  // R3: a low phase ends only after lo_used+1 cycles
  a_r3_low_length: assert property (@(posedge clk) disable iff (rst || !en)
    (state == PH_LOW && cnt == '0) |-> (lo_seen == lo_used));
  // R7: disable releases SCL at the edge
  a_r7_disable_release: assert property (@(posedge clk) disable iff (rst)
    !en |=> !oe);
  // R6: a low sampled line keeps the block waiting
  a_r6_stretch_wait: assert property (@(posedge clk) disable iff (rst)
    (state == PH_WAIT && !scl_q && en) |=> (state == PH_WAIT));
  // R3: output pulls low exactly while in the low phase
  a_r3_oe_matches_phase: assert property (@(posedge clk) disable iff (rst)
    oe == (state == PH_LOW));
endmodule

// File: rtl/scl_gen.sv
module scl_gen #(
  parameter int CNT_W = 16,
  parameter int RST_STD_HI = 20,
  parameter int RST_STD_LO = 30,
  parameter int RST_FAST_HI = 4,
  parameter int RST_FAST_LO = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_en,
  input  logic             ctl_run,
  input  logic [1:0]       ctl_speed,
  input  logic             cnt_we,
  input  logic [1:0]       cnt_sel,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             scl_in,
  output logic             scl_oe
);
  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic             scl_q;

  scl_count_bank #(
    .CNT_W(CNT_W), .RST_STD_HI(RST_STD_HI), .RST_STD_LO(RST_STD_LO),
    .RST_FAST_HI(RST_FAST_HI), .RST_FAST_LO(RST_FAST_LO)
  ) u_bank (
    .clk(clk), .rst(rst), .en(ctl_en), .speed(ctl_speed),
    .we(cnt_we), .sel(cnt_sel), .wdata(cnt_wdata),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt)
  );

  scl_sampler u_samp (
    .clk(clk), .rst(rst), .pad_in(scl_in), .level_q(scl_q)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .en(ctl_en), .run(ctl_run), .scl_q(scl_q),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .oe(scl_oe)
  );
endmodule

// File: tb/scl_gen_tb.sv
module scl_gen_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_en = 1'b0, ctl_run = 1'b0;
  logic [1:0] ctl_speed = 2'b01;
  logic cnt_we = 1'b0;
  logic [1:0] cnt_sel = '0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic hold = 1'b0;
  logic scl_in, scl_oe;

  assign scl_in = !(scl_oe || hold);

  always #2.5 clk = !clk;

  scl_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_run(ctl_run),
    .ctl_speed(ctl_speed), .cnt_we(cnt_we), .cnt_sel(cnt_sel),
    .cnt_wdata(cnt_wdata), .scl_in(scl_in), .scl_oe(scl_oe)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cnt_we = 1'b1; cnt_sel = 2'(sel); cnt_wdata = CNT_W'(val);
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic wait_rise();
    while (scl_oe !== 1'b1) @(negedge clk);
  endtask

  task automatic count_while(input logic v, output int n);
    n = 0;
    while (scl_oe === v && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic stop_all();
    @(negedge clk);
    ctl_run = 1'b0; ctl_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic sweep(input logic [1:0] spd, input int hi, input int lo);
    int nl, nh;
    if (spd == 2'b10) begin wr(2, hi); wr(3, lo); end
    else begin wr(0, hi); wr(1, lo); end
    ctl_speed = spd;
    @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
    wait_rise();
    for (int p = 0; p < 2; p++) begin
      count_while(1'b1, nl);
      check(nl == lo + 1, "R3 low length", nl, lo + 1);
      count_while(1'b0, nh);
      check(nh == hi + 8, "R5 high length", nh, hi + 8);
    end
    stop_all();
  endtask

  initial begin
    int nl, nh, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(scl_oe == 1'b0, "R1 reset release", scl_oe, 0);

    // R1 defaults, R3 start latency
    ctl_speed = 2'b01; ctl_en = 1'b1; ctl_run = 1'b1;
    @(negedge clk);
    check(scl_oe == 1'b1, "R3 start at next edge", scl_oe, 1);
    count_while(1'b1, nl);
    check(nl == 31, "R1 default std low", nl, 31);
    count_while(1'b0, nh);
    check(nh == 28, "R1 default std high", nh, 28);
    stop_all();
    ctl_speed = 2'b10; @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
    wait_rise();
    count_while(1'b1, nl);
    check(nl == 10, "R1 R2 default fast low", nl, 10);
    count_while(1'b0, nh);
    check(nh == 12, "R1 R2 default fast high", nh, 12);
    stop_all();

    // R2 unused speed codes select standard
    ctl_speed = 2'b00; @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
    wait_rise(); count_while(1'b1, nl);
    check(nl == 31, "R2 code 00 is standard", nl, 31);
    stop_all();
    ctl_speed = 2'b11; @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
    wait_rise(); count_while(1'b1, nl);
    check(nl == 31, "R2 code 11 is standard", nl, 31);
    stop_all();

    // R3 R4 R5 sweep over small counts in both modes
    for (int h = 0; h < 5; h++)
      for (int l = 0; l < 5; l++) begin
        sweep(2'b01, h, l + 1);
        sweep(2'b10, h + 2, l);
      end

    // R4 write while enabled is ignored
    wr(1, 6); wr(0, 3); ctl_speed = 2'b01;
    @(negedge clk); ctl_en = 1'b1;
    wr(1, 12);
    ctl_run = 1'b1;
    wait_rise(); count_while(1'b1, nl);
    check(nl == 7, "R4 locked write ignored", nl, 7);
    stop_all();

    // R6 stretch by S cycles
    for (int s = 1; s < 6; s++) begin
      @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
      wait_rise();
      hold = 1'b1;
      count_while(1'b1, nl);
      repeat (s - 1) @(negedge clk);
      hold = 1'b0;
      count_while(1'b0, nh);
      check(s - 1 + nh == 3 + 7 + s, "R6 stretched high", s - 1 + nh, 3 + 7 + s);
      stop_all();
    end

    // R7 disable mid low
    @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
    wait_rise(); @(negedge clk);
    ctl_en = 1'b0;
    @(negedge clk);
    check(scl_oe == 1'b0, "R7 disable releases", scl_oe, 1'b0);
    count_while(1'b0, n);
    check(n >= 20, "R7 stays idle", n, 20);
    ctl_run = 1'b0;

    // R8 run drop in last low cycle and in first low cycle
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
      wait_rise();
      if (k == 0) repeat (6) @(negedge clk);
      ctl_run = 1'b0;
      n = (k == 0) ? 6 : 0;
      count_while(1'b1, nl);
      check(nl + n == 7, "R8 low completes", nl + n, 7);
      count_while(1'b0, nh);
      check(nh >= 40, "R8 idle after low", nh, 40);
      stop_all();
    end

    // R8 run drop during high
    @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
    wait_rise(); count_while(1'b1, nl);
    @(negedge clk); ctl_run = 1'b0;
    count_while(1'b0, nh);
    check(nh >= 40, "R8 idle after high", nh, 40);
    ctl_run = 1'b1; @(negedge clk); @(negedge clk);
    check(scl_oe == 1'b1, "R8 resumes on run", scl_oe, 1);
    stop_all();

    // R9 speed change during low
    wr(2, 1); wr(3, 2); ctl_speed = 2'b10;
    @(negedge clk); ctl_en = 1'b1; ctl_run = 1'b1;
    wait_rise();
    ctl_speed = 2'b01;
    count_while(1'b1, nl);
    check(nl == 3, "R9 current low keeps fast", nl, 3);
    count_while(1'b0, nh);
    check(nh == 11, "R9 next high uses std", nh, 11);
    count_while(1'b1, nl);
    check(nl == 7, "R9 next low uses std", nl, 7);
    stop_all();

    finish_run();
  end
endmodule